// File: doc/BRIEF.md
# Memory Security Key Unlock Controller

This block holds the security state of a small microcontroller's protected memory. In the first clock cycle after reset it takes a 2-bit security option field, a key-enable option bit and a 64-bit comparison key from nonvolatile storage. From these it decides whether the part starts secure. While the part is secure, every memory access request is judged by where it comes from. Requests from the debug port, or from code running in non-secure memory, are refused.

There are two ways to lift security. The first is a key sequence: eight byte writes, in index order, made by code running in secure memory. This route is open only when the key-enable bit is set, and a wrong key locks it until the next reset. The second is a mass erase. Security is lifted when the erase-done strobe arrives together with a passing blank check. Either route lifts security only until the next reset, when the stored option field is applied again. The flash array, the erase engine and the CPU are outside this block and reach it only as request and status pins.

Top module: `sec_unlock_ctrl`

## Requirements
- R1: While reset is asserted and during the single load cycle that follows it, `secure` is 1 and `grant` is 0. The option field, the key-enable bit and the key are captured at the first rising edge after `rst_n` goes high.
- R2: A captured option field of 2'b10 (bit 1 high, bit 0 low) leaves the part unsecured after the load cycle. The values 2'b00, 2'b01 and 2'b11 leave it secure.
- R3: After the load cycle, `grant` follows `req_valid` in the same cycle, with one exception. While secure, a request with `req_from_debug`=1 or `req_from_secure_code`=0 is refused.
- R4: A key write counts only when all of the following hold: `key_wr`=1, `key_from_secure_code`=1, `key_from_debug`=0, key-enable captured as 1, the part secure, and no lockout. Any other key write changes neither `secure` nor the progress of an attempt under way.
- R5: Key bytes must arrive with `key_idx` running 0 to 7. The byte at index i is compared with bits [8i+7:8i] of the captured key. If all eight match, `secure` drops at the clock edge that samples the write at index 7.
- R6: A counted write whose index is not the next one expected cancels the attempt without a lockout. If that write has index 0, it starts a new attempt.
- R7: A complete eight-byte sequence with any mismatching byte leaves the part secure. No later key sequence can unsecure it until the next reset.
- R8: `erase_done`=1 together with `blank_ok`=1 clears `secure` at that edge, whatever the key-enable bit or the lockout. `erase_done` with `blank_ok`=0 keeps the part secure, and `blank_ok` without `erase_done` has no effect.
- R9: Once unsecured, the part stays unsecured until reset. A new reset applies the option field again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nv_sec_field | input | 2 | Stored security option field |
| nv_key_en | input | 1 | Stored key-enable option bit |
| nv_key | input | 64 | Stored comparison key, byte i at bits [8i+7:8i] |
| key_wr | input | 1 | Key byte write strobe |
| key_idx | input | 3 | Index of the key byte being written |
| key_byte | input | 8 | Candidate key byte |
| key_from_secure_code | input | 1 | Key write issued by code in secure memory |
| key_from_debug | input | 1 | Key write issued through the debug port |
| req_valid | input | 1 | Memory access request |
| req_from_debug | input | 1 | Request originates at the debug port |
| req_from_secure_code | input | 1 | Request issued by code in secure memory |
| erase_done | input | 1 | Mass erase finished strobe |
| blank_ok | input | 1 | Blank check result, sampled with erase_done |
| secure | output | 1 | Security state |
| grant | output | 1 | Access grant for the current request |

## Verification
A wrong security state shows up at once on two ports. `secure` changes at the edge that samples the event. `grant` gives a different answer for a debug or non-secure request in the same cycle. Errors in the sequence tracker, such as a lost index, a stray restart or a missed lockout, show only at the edge that samples the eighth write. The bench therefore checks `secure` both after the seventh write and after the eighth. It also follows a wrong key with a correct one, so that a missing lockout is exposed, and it slips ignored writes into an attempt that is still running.

// File: rtl/sec_unlock_pkg.sv
package sec_unlock_pkg;

    localparam logic [1:0] SEC_OPEN_CODE = 2'b10;

    function automatic logic sec_field_is_secure(input logic [1:0] field);
        return field != SEC_OPEN_CODE;
    endfunction

endpackage

// File: rtl/sec_key_mux.sv
module sec_key_mux #(
    parameter int KEY_BYTES = 8,
    parameter int BYTE_W    = 8,
    parameter int IDX_W     = 3
) (
    input  logic [KEY_BYTES*BYTE_W-1:0] key_flat,
    input  logic [IDX_W-1:0]            sel_idx,
    output logic [BYTE_W-1:0]           sel_byte
);
    logic [BYTE_W-1:0] slice [KEY_BYTES];

    for (genvar g = 0; g < KEY_BYTES; g++) begin : g_slice
        assign slice[g] = key_flat[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        sel_byte = '0;
        for (int i = 0; i < KEY_BYTES; i++) begin
            if (sel_idx == IDX_W'(i)) sel_byte = slice[i];
        end
    end
endmodule

// File: rtl/sec_key_seq.sv
module sec_key_seq #(
    parameter int BYTE_W    = 8,
    parameter int KEY_BYTES = 8,
    parameter int IDX_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              allow,
    input  logic              wr_ok,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic [BYTE_W-1:0] ref_byte,
    output logic              done_hit,
    output logic              done_miss
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(KEY_BYTES - 1);

    typedef struct packed {
        logic [IDX_W-1:0] expect_idx;
        logic             match;
    } seq_t;

    seq_t seq_d, seq_q;
    logic byte_eq;

    always_comb begin
        seq_d     = seq_q;
        done_hit  = 1'b0;
        done_miss = 1'b0;
        byte_eq   = (wr_byte == ref_byte);
        if (!allow) begin
            seq_d.expect_idx = '0;
            seq_d.match      = 1'b1;
        end else if (wr_ok) begin
            if (wr_idx == seq_q.expect_idx) begin
                if (seq_q.expect_idx == LAST_IDX) begin
                    done_hit         = seq_q.match & byte_eq;
                    done_miss        = ~(seq_q.match & byte_eq);
                    seq_d.expect_idx = '0;
                    seq_d.match      = 1'b1;
                end else begin
                    seq_d.expect_idx = seq_q.expect_idx + IDX_W'(1);
                    seq_d.match      = seq_q.match & byte_eq;
                end
            end else if (wr_idx == '0) begin
                seq_d.expect_idx = IDX_W'(1);
                seq_d.match      = byte_eq;
            end else begin
                seq_d.expect_idx = '0;
                seq_d.match      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.expect_idx <= '0;
            seq_q.match      <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end
endmodule

// File: rtl/sec_access_gate.sv
module sec_access_gate (
    input  logic loaded,
    input  logic secure,
    input  logic req_valid,
    input  logic req_from_debug,
    input  logic req_from_secure_code,
    output logic grant
);
    logic trusted;

    always_comb begin
        trusted = req_from_secure_code & ~req_from_debug;
        grant   = loaded & req_valid & (~secure | trusted);
    end
endmodule

// File: rtl/sec_unlock_ctrl.sv
module sec_unlock_ctrl #(
    parameter int KEY_BYTES = 8,
    parameter int BYTE_W    = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [1:0]                         nv_sec_field,
    input  logic                               nv_key_en,
    input  logic [KEY_BYTES*BYTE_W-1:0]        nv_key,
    input  logic                               key_wr,
    input  logic [$clog2(KEY_BYTES)-1:0]       key_idx,
    input  logic [BYTE_W-1:0]                  key_byte,
    input  logic                               key_from_secure_code,
    input  logic                               key_from_debug,
    input  logic                               req_valid,
    input  logic                               req_from_debug,
    input  logic                               req_from_secure_code,
    input  logic                               erase_done,
    input  logic                               blank_ok,
    output logic                               secure,
    output logic                               grant
);
    import sec_unlock_pkg::*;

    localparam int IDX_W = $clog2(KEY_BYTES);
    localparam int KEY_W = KEY_BYTES * BYTE_W;

    typedef struct packed {
        logic             loaded;
        logic             secure;
        logic             key_en;
        logic             locked;
        logic [KEY_W-1:0] key;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              loaded;
    logic              seq_allow;
    logic              seq_wr_ok;
    logic [BYTE_W-1:0] ref_byte;
    logic              key_hit;
    logic              key_miss;

    assign loaded    = ctl_q.loaded;
    assign secure    = ctl_q.secure;
    assign seq_allow = ctl_q.loaded & ctl_q.secure & ctl_q.key_en & ~ctl_q.locked;
    assign seq_wr_ok = key_wr & key_from_secure_code & ~key_from_debug;

    sec_key_mux #(.KEY_BYTES(KEY_BYTES), .BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_mux (
        .key_flat (ctl_q.key),
        .sel_idx  (key_idx),
        .sel_byte (ref_byte)
    );

    sec_key_seq #(.BYTE_W(BYTE_W), .KEY_BYTES(KEY_BYTES), .IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .allow     (seq_allow),
        .wr_ok     (seq_wr_ok),
        .wr_idx    (key_idx),
        .wr_byte   (key_byte),
        .ref_byte  (ref_byte),
        .done_hit  (key_hit),
        .done_miss (key_miss)
    );

    sec_access_gate u_gate (
        .loaded               (ctl_q.loaded),
        .secure               (ctl_q.secure),
        .req_valid            (req_valid),
        .req_from_debug       (req_from_debug),
        .req_from_secure_code (req_from_secure_code),
        .grant                (grant)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (!ctl_q.loaded) begin
            ctl_d.loaded = 1'b1;
            ctl_d.secure = sec_field_is_secure(nv_sec_field);
            ctl_d.key_en = nv_key_en;
            ctl_d.key    = nv_key;
            ctl_d.locked = 1'b0;
        end else begin
            if (erase_done && blank_ok) ctl_d.secure = 1'b0;
            if (key_hit)                ctl_d.secure = 1'b0;
            if (key_miss)               ctl_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.loaded <= 1'b0;
            ctl_q.secure <= 1'b1;
            ctl_q.key_en <= 1'b0;
            ctl_q.locked <= 1'b0;
            ctl_q.key    <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/sec_unlock_chk.sv
module sec_unlock_chk (
    input logic clk,
    input logic rst_n,
    input logic loaded,
    input logic secure,
    input logic grant,
    input logic req_valid,
    input logic req_from_debug,
    input logic req_from_secure_code,
    input logic key_wr,
    input logic key_from_debug,
    input logic erase_done,
    input logic blank_ok
);
    assert_load_closed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !loaded |-> (secure && !grant));

    assert_grant_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> req_valid);

    assert_debug_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (secure && (req_from_debug || !req_from_secure_code)) |-> !grant);

    assert_debug_key_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded && secure && key_wr && key_from_debug && !erase_done) |=> secure);

    assert_unlock_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(secure) && $past(loaded)) |-> ($past(key_wr) || $past(erase_done && blank_ok)));

    assert_nonblank_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded && secure && erase_done && !blank_ok && !key_wr) |=> secure);

    assert_stays_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (loaded && !secure) |=> !secure);
endmodule

bind sec_unlock_ctrl sec_unlock_chk u_chk (
    .clk                  (clk),
    .rst_n                (rst_n),
    .loaded               (loaded),
    .secure               (secure),
    .grant                (grant),
    .req_valid            (req_valid),
    .req_from_debug       (req_from_debug),
    .req_from_secure_code (req_from_secure_code),
    .key_wr               (key_wr),
    .key_from_debug       (key_from_debug),
    .erase_done           (erase_done),
    .blank_ok             (blank_ok)
);

// File: tb/tb_sec_unlock_ctrl.sv
module tb_sec_unlock_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  nv_sec_field = 2'b11;
    logic        nv_key_en = 1'b1;
    logic [63:0] nv_key = '0;
    logic        key_wr = 1'b0;
    logic [2:0]  key_idx = '0;
    logic [7:0]  key_byte = '0;
    logic        key_from_secure_code = 1'b0;
    logic        key_from_debug = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_from_debug = 1'b0;
    logic        req_from_secure_code = 1'b0;
    logic        erase_done = 1'b0;
    logic        blank_ok = 1'b0;
    logic        secure;
    logic        grant;

    int n_total = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sec_unlock_ctrl dut (
        .clk(clk), .rst_n(rst_n), .nv_sec_field(nv_sec_field), .nv_key_en(nv_key_en),
        .nv_key(nv_key), .key_wr(key_wr), .key_idx(key_idx), .key_byte(key_byte),
        .key_from_secure_code(key_from_secure_code), .key_from_debug(key_from_debug),
        .req_valid(req_valid), .req_from_debug(req_from_debug),
        .req_from_secure_code(req_from_secure_code), .erase_done(erase_done),
        .blank_ok(blank_ok), .secure(secure), .grant(grant)
    );

    function automatic logic exp_secure(input logic [1:0] f);
        return f != 2'b10;
    endfunction

    function automatic logic exp_grant(input logic sec, input logic v, input logic dbg, input logic sc);
        return v && (!sec || (sc && !dbg));
    endfunction

    function automatic logic [7:0] key_at(input logic [63:0] k, input int i);
        return k[8*i +: 8];
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] f, input logic ken, input logic [63:0] k);
        nv_sec_field = f; nv_key_en = ken; nv_key = k;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        req_valid = 1'b1; req_from_secure_code = 1'b1; req_from_debug = 1'b0;
        #1;
        chk("R1 secure during load", secure, 1'b1);
        chk("R1 grant during load", grant, 1'b0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 secure after load", secure, exp_secure(f));
    endtask

    task automatic key_write(input int idx, input logic [7:0] b, input logic sc, input logic dbg);
        key_wr = 1'b1; key_idx = 3'(idx); key_byte = b;
        key_from_secure_code = sc; key_from_debug = dbg;
        @(negedge clk);
        key_wr = 1'b0; key_from_secure_code = 1'b0; key_from_debug = 1'b0;
    endtask

    task automatic send_key(input logic [63:0] k, input logic sc, input logic dbg);
        for (int i = 0; i < 8; i++) key_write(i, key_at(k, i), sc, dbg);
    endtask

    task automatic erase(input logic done, input logic ok);
        erase_done = done; blank_ok = ok;
        @(negedge clk);
        erase_done = 1'b0; blank_ok = 1'b0;
    endtask

    task automatic rand_grant(input int n, input logic sec);
        for (int i = 0; i < n; i++) begin
            req_valid = 1'($urandom);
            req_from_debug = 1'($urandom);
            req_from_secure_code = 1'($urandom);
            #1;
            chk("R3 grant", grant, exp_grant(sec, req_valid, req_from_debug, req_from_secure_code));
            chk("R9 secure holds", secure, sec);
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] k;
        logic [63:0] wrong;
        void'($urandom(32'd4242));
        k = {$urandom, $urandom};
        wrong = k ^ (64'h1 << 27);
        @(negedge clk);
        #1;
        chk("R1 secure in reset", secure, 1'b1);

        for (int f = 0; f < 4; f++) do_reset(2'(f), 1'b1, k);   // R2 all encodings

        do_reset(2'b11, 1'b1, k);
        rand_grant(60, 1'b1);                                    // R3 secure

        send_key(k, 1'b1, 1'b1);
        chk("R4 debug key ignored", secure, 1'b1);
        send_key(k, 1'b0, 1'b0);
        chk("R4 non-secure code key ignored", secure, 1'b1);
        for (int i = 0; i < 4; i++) key_write(i, key_at(k, i), 1'b1, 1'b0);
        key_write(6, 8'h00, 1'b1, 1'b1);
        key_write(2, 8'h00, 1'b0, 1'b0);
        for (int i = 4; i < 8; i++) key_write(i, key_at(k, i), 1'b1, 1'b0);
        chk("R4 ignored writes keep progress", secure, 1'b0);

        do_reset(2'b00, 1'b0, k);
        send_key(k, 1'b1, 1'b0);
        chk("R4 key disabled ignored", secure, 1'b1);
        erase(1'b1, 1'b1);
        chk("R8 erase with key disabled", secure, 1'b0);

        do_reset(2'b01, 1'b1, k);
        for (int i = 0; i < 7; i++) key_write(i, key_at(k, i), 1'b1, 1'b0);
        chk("R5 secure after seven bytes", secure, 1'b1);
        key_write(7, key_at(k, 7), 1'b1, 1'b0);
        chk("R5 unlock at eighth byte", secure, 1'b0);
        rand_grant(60, 1'b0);                                    // R3 open, R9 hold

        do_reset(2'b11, 1'b1, k);
        key_write(0, key_at(k, 0), 1'b1, 1'b0);
        key_write(1, key_at(k, 1), 1'b1, 1'b0);
        key_write(3, key_at(k, 3), 1'b1, 1'b0);
        for (int i = 4; i < 8; i++) key_write(i, key_at(k, i), 1'b1, 1'b0);
        chk("R6 skipped index aborts", secure, 1'b1);
        send_key(k, 1'b1, 1'b0);
        chk("R6 no lockout after abort", secure, 1'b0);

        do_reset(2'b11, 1'b1, k);
        for (int i = 0; i < 4; i++) key_write(i, key_at(k, i), 1'b1, 1'b0);
        send_key(k, 1'b1, 1'b0);
        chk("R6 index 0 restarts attempt", secure, 1'b0);

        do_reset(2'b11, 1'b1, k);
        send_key(wrong, 1'b1, 1'b0);
        chk("R7 wrong key stays secure", secure, 1'b1);
        send_key(k, 1'b1, 1'b0);
        chk("R7 locked after miss", secure, 1'b1);
        erase(1'b1, 1'b0);
        chk("R8 non-blank keeps secure", secure, 1'b1);
        erase(1'b0, 1'b1);
        chk("R8 blank_ok alone ignored", secure, 1'b1);
        erase(1'b1, 1'b1);
        chk("R8 erase unlocks when locked", secure, 1'b0);

        do_reset(2'b11, 1'b1, k);
        chk("R9 reset re-secures", secure, 1'b1);
        send_key(k, 1'b1, 1'b0);
        chk("R7 lockout cleared by reset", secure, 1'b0);
        erase(1'b1, 1'b0);
        send_key(wrong, 1'b1, 1'b0);
        chk("R9 stays open", secure, 1'b0);

        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule